// File: doc/BRIEF.md
# Cascadable Nibble Serializer

The block turns a four-bit parallel word into a serial NRZ bit stream, one bit per input clock, least significant bit first. All of its registers change on the falling edge of the input clock. An eight-phase sequencer decides when the shift chain captures the parallel word. The same sequencer produces a quarter-rate clock and an eighth-rate clock, both brought out as outputs.

In narrow mode the word is captured every fourth falling edge. In wide mode it is captured every eighth falling edge. Wide mode lets two instances run as one 8:1 serializer. The serial output of the unit carrying bits 4..7 feeds the serial input of the unit carrying bits 0..3. The lower unit then emits bits 0..7 in that order. For this to work, the clock-to-output delay plus the serial-input setup time has to fit inside one clock period.

An active-high `sync` input clears the sequencer, the divided clocks and the chain asynchronously. Releasing it fixes where the next conversion starts. The sequencer walks through the states PH0 to PH7 in a ring, PH0→PH1→…→PH7→PH0, one step per falling edge. `sync` forces it to PH0. A load happens in state PH7 in either mode, and also in PH3 in narrow mode.

Top module: `nibble_serializer`

## Requirements
- R1: After a load edge, `ser_out` presents `par_in[0]`. It then presents `par_in[1]`, `par_in[2]` and `par_in[3]` on the next three falling edges.
- R2: `ser_out`, `clk_div4` and `clk_div8` change only on falling edges of `clk`, apart from the asynchronous clear by `sync`.
- R3: With `wide_mode` = 0, a load happens on the 4th falling edge after `sync` is released and on every 4th falling edge after that.
- R4: With `wide_mode` = 1, a load happens on the 8th falling edge after `sync` is released and on every 8th falling edge after that. There is no load in between.
- R5: `par_in` is sampled only on load edges. Its value on any other edge has no effect on `ser_out`.
- R6: `ser_in` enters the chain behind bit 3. In narrow mode it never reaches `ser_out`. In wide mode, the values `ser_in` held on the four falling edges that follow a load appear on `ser_out` in the four edges after bit 3.
- R7: Let n be the count of falling edges since `sync` was released. Then `clk_div4` equals bit 1 of (n mod 8) and `clk_div8` equals bit 2 of (n mod 8). Both outputs start low.
- R8: While `sync` is 1, `ser_out`, `clk_div4` and `clk_div8` are 0. Raising `sync` clears them at once, with no clock edge needed.
- R9: Two wide-mode units can be chained, with the upper unit's `ser_out` driving the lower unit's `ser_in`. The upper unit takes bits 7..4 and the lower unit takes bits 3..0. The lower unit's `ser_out` then carries bits 0 through 7 in order, one per falling edge, starting at the shared load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its falling edge |
| sync | input | 1 | Asynchronous active-high clear and restart |
| wide_mode | input | 1 | 0: load every 4 edges; 1: load every 8 edges |
| par_in | input | NIB_W | Parallel word, bit 0 sent first |
| ser_in | input | 1 | Cascade input, enters behind bit 3 |
| ser_out | output | 1 | Serial NRZ data |
| clk_div4 | output | 1 | Input clock divided by 4 |
| clk_div8 | output | 1 | Input clock divided by 8 |

## Verification
Suppose the sequencer lands in the wrong state. The divided clocks then show a wrong phase on the very next falling edge. The load shifts in time, so the bits on `ser_out` come out rotated within at most one period of four or eight edges. A chain stage that takes the wrong neighbour shows up as a misplaced bit within four edges of the next load. In a cascade, a broken path from `ser_in` corrupts bits 4..7 of the first byte.

// File: rtl/ser_pkg.sv
package ser_pkg;
    // Sequencer phases; the ring length is twice the nibble width.
    localparam int NIB_W   = 4;
    localparam int RING_N  = 2 * NIB_W;

    typedef enum logic [2:0] {
        PH0 = 3'd0, PH1 = 3'd1, PH2 = 3'd2, PH3 = 3'd3,
        PH4 = 3'd4, PH5 = 3'd5, PH6 = 3'd6, PH7 = 3'd7
    } phase_e;
endpackage

// File: rtl/ser_phase_seq.sv
module ser_phase_seq
    import ser_pkg::*;
(
    input  logic   clk,
    input  logic   sync,
    input  logic   wide_mode,
    output logic   load_pulse,
    output logic   div4_q,
    output logic   div8_q
);
    phase_e phase_q;
    phase_e phase_d;

    // State register: falling edge, asynchronous clear to PH0.
    always_ff @(negedge clk or posedge sync) begin
        if (sync) phase_q <= PH0;
        else      phase_q <= phase_d;
    end

    // Ring transitions.
    always_comb begin
        unique case (phase_q)
            PH0: phase_d = PH1;
            PH1: phase_d = PH2;
            PH2: phase_d = PH3;
            PH3: phase_d = PH4;
            PH4: phase_d = PH5;
            PH5: phase_d = PH6;
            PH6: phase_d = PH7;
            PH7: phase_d = PH0;
        endcase
    end

    // Outputs: load decode, plus registered divided clocks taken from the next phase.
    always_comb begin
        unique case (phase_q)
            PH3:     load_pulse = !wide_mode;
            PH7:     load_pulse = 1'b1;
            default: load_pulse = 1'b0;
        endcase
    end

    always_ff @(negedge clk or posedge sync) begin
        if (sync) begin
            div4_q <= 1'b0;
            div8_q <= 1'b0;
        end else begin
            div4_q <= phase_d inside {PH2, PH3, PH6, PH7};
            div8_q <= phase_d inside {PH4, PH5, PH6, PH7};
        end
    end
endmodule

// File: rtl/ser_shift_chain.sv
module ser_shift_chain #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         sync,
    input  logic         load,
    input  logic [W-1:0] par,
    input  logic         ser_in,
    output logic         ser_out
);
    logic [W-1:0] stage_q;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic feed;
        if (i == W - 1) begin : g_tail
            assign feed = ser_in;
        end else begin : g_body
            assign feed = stage_q[i+1];
        end

        always_ff @(negedge clk or posedge sync) begin
            if (sync)      stage_q[i] <= 1'b0;
            else if (load) stage_q[i] <= par[i];
            else           stage_q[i] <= feed;
        end
    end

    assign ser_out = stage_q[0];
endmodule

// File: rtl/nibble_serializer.sv
module nibble_serializer #(
    parameter int NIB_W = ser_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             sync,
    input  logic             wide_mode,
    input  logic [NIB_W-1:0] par_in,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             clk_div4,
    output logic             clk_div8
);
    logic load_pulse;

    ser_phase_seq u_seq (
        .clk        (clk),
        .sync       (sync),
        .wide_mode  (wide_mode),
        .load_pulse (load_pulse),
        .div4_q     (clk_div4),
        .div8_q     (clk_div8)
    );

    ser_shift_chain #(.W(NIB_W)) u_chain (
        .clk     (clk),
        .sync    (sync),
        .load    (load_pulse),
        .par     (par_in),
        .ser_in  (ser_in),
        .ser_out (ser_out)
    );
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             sync,
    input logic             wide_mode,
    input logic [NIB_W-1:0] par_in,
    input logic             ser_out,
    input logic             clk_div4,
    input logic             clk_div8,
    input logic             load_pulse
);
    logic [3:0] gap_q;

    // Edges since the last load, or since the release of sync.
    always_ff @(negedge clk or posedge sync) begin
        if (sync)                gap_q <= 4'd0;
        else if (load_pulse)     gap_q <= 4'd0;
        else if (gap_q != 4'hF)  gap_q <= gap_q + 4'd1;
    end

    assert_narrow_period_R3: assert property (@(negedge clk) disable iff (sync)
        (load_pulse && !wide_mode) |-> gap_q == 4'd3);

    assert_wide_period_R4: assert property (@(negedge clk) disable iff (sync)
        (load_pulse && wide_mode) |-> gap_q == 4'd7);

    assert_first_bit_R1: assert property (@(negedge clk) disable iff (sync)
        load_pulse |=> ser_out == $past(par_in[0]));

    assert_div8_on_div4_fall_R7: assert property (@(negedge clk) disable iff (sync)
        !$stable(clk_div8) |-> $fell(clk_div4));

    assert_div4_half_rate_R7: assert property (@(negedge clk) disable iff (sync)
        !$stable(clk_div4) |=> $stable(clk_div4));

    always @(negedge clk) begin
        if (sync) begin
            assert_cleared_R8: assert (!ser_out && !clk_div4 && !clk_div8);
        end
    end
endmodule

bind nibble_serializer ser_checker #(.NIB_W(NIB_W)) u_ser_checker (
    .clk        (clk),
    .sync       (sync),
    .wide_mode  (wide_mode),
    .par_in     (par_in),
    .ser_out    (ser_out),
    .clk_div4   (clk_div4),
    .clk_div8   (clk_div8),
    .load_pulse (load_pulse)
);

// File: tb/nibble_serializer_test.sv
module nibble_serializer_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    idx;
        logic  bitv;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       sync = 1'b1;
    logic       mode = 1'b0;
    logic [3:0] lo_par = 4'd0;
    logic [3:0] hi_par = 4'd0;
    logic       noise = 1'b0;
    logic       lo_sin, lo_sout, hi_sout;
    logic       div4, div8, hi_div4, hi_div8;

    int   checks = 0;
    int   fails = 0;
    int   e = 0;
    bit   running = 1'b0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign lo_sin = mode ? hi_sout : noise;

    nibble_serializer uut (
        .clk(clk), .sync(sync), .wide_mode(mode), .par_in(lo_par),
        .ser_in(lo_sin), .ser_out(lo_sout), .clk_div4(div4), .clk_div8(div8)
    );

    nibble_serializer upper (
        .clk(clk), .sync(sync), .wide_mode(mode), .par_in(hi_par),
        .ser_in(1'b0), .ser_out(hi_sout), .clk_div4(hi_div4), .clk_div8(hi_div8)
    );

    // Falling edges since the release of sync.
    always @(negedge clk or posedge sync) begin
        if (sync) e <= 0;
        else      e <= e + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", tag, act, exp, e);
        end
    endtask

    // Monitor: sampled on rising edges, half a period after the design moves.
    always @(posedge clk) begin
        if (running && !sync) begin
            check(div4 == (((e % 8) >> 1) & 1), "R7 div4", div4, ((e % 8) >> 1) & 1);
            check(div8 == (((e % 8) >> 2) & 1), "R7 div8", div8, ((e % 8) >> 2) & 1);
            while (q.size() > 0 && q[0].idx < e) begin
                check(1'b0, {q[0].tag, " missed bit"}, e, q[0].idx);
                void'(q.pop_front());
            end
            if (q.size() > 0 && q[0].idx == e) begin
                check(lo_sout == q[0].bitv, q[0].tag, lo_sout, q[0].bitv);
                void'(q.pop_front());
            end
        end
    end

    // Cascade noise on the lower unit's serial input in narrow mode (R6).
    always @(posedge clk) noise <= 1'($urandom);

    // Driver: narrow mode, one nibble per load (R1, R3, R5, R6).
    task automatic send_nibble(input logic [3:0] w, input string tag);
        while (((e + 1) % 4) != 0) @(posedge clk);
        lo_par = w;
        for (int i = 0; i < 4; i++) q.push_back('{e + 1 + i, w[i], tag});
        @(posedge clk);
        lo_par = 4'($urandom);
    endtask

    // Driver: wide-mode cascade, one byte per load (R4, R9).
    task automatic send_byte(input logic [7:0] b, input string tag);
        while (((e + 1) % 8) != 0) @(posedge clk);
        lo_par = b[3:0];
        hi_par = b[7:4];
        for (int i = 0; i < 8; i++) q.push_back('{e + 1 + i, b[i], tag});
        @(posedge clk);
        lo_par = 4'($urandom);
        hi_par = 4'($urandom);
    endtask

    task automatic release_sync();
        @(posedge clk);
        sync = 1'b0;
        running = 1'b1;
    endtask

    initial begin
        // Reset state (R8)
        repeat (3) @(posedge clk);
        check(lo_sout == 1'b0, "R8 reset ser_out", lo_sout, 0);
        check(div4 == 1'b0 && div8 == 1'b0, "R8 reset divs", {div4, div8}, 0);

        // Narrow mode: first load on the 4th edge (R3), bit order (R1)
        release_sync();
        send_nibble(4'b0010, "R3 first load");
        send_nibble(4'b1101, "R1 order");
        send_nibble(4'b0110, "R5 sampling");
        for (int k = 0; k < 6; k++) send_nibble(4'($urandom), "R6 narrow noise");
        send_nibble(4'b1111, "R1 ones");

        // Asynchronous clear mid-stream (R8)
        #(CLK_PERIOD/4);
        sync = 1'b1;
        running = 1'b0;
        #1;
        check(lo_sout == 1'b0, "R8 async ser_out", lo_sout, 0);
        check(div4 == 1'b0 && div8 == 1'b0, "R8 async divs", {div4, div8}, 0);
        q.delete();
        repeat (3) @(posedge clk);
        check(lo_sout == 1'b0, "R8 held ser_out", lo_sout, 0);

        // Restart: first load again on the 4th edge (R3, R2 phase)
        release_sync();
        send_nibble(4'b1000, "R3 restart");
        send_nibble(4'b0101, "R1 restart order");

        // Wide-mode cascade (R4, R6, R9)
        @(posedge clk);
        sync = 1'b1;
        running = 1'b0;
        q.delete();
        mode = 1'b1;
        repeat (2) @(posedge clk);
        release_sync();
        send_byte(8'b0000_0010, "R4 first load");
        send_byte(8'b1000_0000, "R6 cascade tail");
        send_byte(8'hA5, "R9 cascade");
        send_byte(8'h3C, "R9 cascade");
        for (int k = 0; k < 6; k++) send_byte(8'($urandom), "R9 cascade rand");
        repeat (12) @(posedge clk);
        check(q.size() == 0, "R9 stream drained", q.size(), 0);

        running = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule